// File: doc/BRIEF.md
# Accumulator ALU with Flag Rules

A purely combinational arithmetic and logic unit for an 8-bit accumulator machine. Each cycle the surrounding datapath presents an operation code, the present accumulator, a register operand, the present carry/borrow flag and the present extension register. The unit returns the next accumulator, extension and carry/borrow values, plus three write enables that tell the datapath which of those state elements the operation is allowed to change.

The key behaviour is the per-operation write rule:

- Multiply and divide spill a second result byte into the extension register.
- Compare touches only the flag.
- Shifts, rotates and bitwise logic change only the accumulator.

Whenever an enable is low, the matching output simply repeats its input. The datapath may therefore either gate its registers with the enables or load the outputs unconditionally.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 (no-op) and the unused code 15 raise no write enable. For every operation, each output whose enable is low equals the matching input (acc_o=acc_i, ext_o=ext_i, cb_o=cb_i).
- R2: Code 1 (add) gives acc_o=(acc_i+opnd_i) mod 256 and cb_o=carry out of bit 7, with the accumulator and flag enables high.
- R3: Code 2 (subtract) gives acc_o=(acc_i-opnd_i) mod 256 and cb_o=1 exactly when acc_i<opnd_i, with the accumulator and flag enables high.
- R4: Code 7 (compare) sets cb_o=1 when acc_i<opnd_i and 0 otherwise, with only the flag enable high.
- R5: Code 3 (multiply) forms the unsigned 16-bit product; the low byte goes to acc_o and the high byte to ext_o, with the accumulator and extension enables high.
- R6: Code 4 (divide) with a non-zero opnd_i gives the unsigned quotient on acc_o and the remainder on ext_o, with the accumulator and extension enables high.
- R7: Code 4 with opnd_i=0 gives acc_o=0xFF and ext_o=acc_i, with the same enables as R6 and the flag enable low.
- R8: Code 8 shifts the accumulator left by one and code 9 shifts it right by one, both filling with zero, with only the accumulator enable high.
- R9: Code 10 rotates the accumulator right by one (bit 0 into bit 7) and code 11 rotates it left by one (bit 7 into bit 0), with only the accumulator enable high.
- R10: Code 12 shifts the accumulator right by one and copies bit 7 into the vacated bit, with only the accumulator enable high.
- R11: Code 5 gives acc_i AND opnd_i and code 6 gives acc_i XOR opnd_i, with only the accumulator enable high.
- R12: Code 13 (increment) and code 14 (decrement) add or subtract one modulo 256. cb_o is 1 only on a wrap (0xFF to 0x00 for code 13, 0x00 to 0xFF for code 14) and is cleared otherwise. The accumulator and flag enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Register operand |
| cb_i | input | 1 | Current carry/borrow flag |
| ext_i | input | 8 | Current extension register |
| acc_o | output | 8 | Next accumulator |
| ext_o | output | 8 | Next extension register |
| cb_o | output | 1 | Next carry/borrow flag |
| acc_we_o | output | 1 | Operation writes the accumulator |
| ext_we_o | output | 1 | Operation writes the extension register |
| cb_we_o | output | 1 | Operation writes the flag |

## Verification
The assertions assume settled inputs and evaluate only after the combinational logic has resolved. The quotient/remainder identity is asserted only for non-zero divisors, and the zero-divisor case is left to its own rule. The stimulus sweeps every operation code against every accumulator and operand value. The incoming flag and extension values are varied at the same time, so that pass-through and zero-divisor behaviour are both exercised without ever leaving the input space the assertions expect.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_MUL = 4'd3,
    OP_DIV = 4'd4,
    OP_AND = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_LSL = 4'd8,
    OP_LSR = 4'd9,
    OP_ROR = 4'd10,
    OP_ROL = 4'd11,
    OP_ASR = 4'd12,
    OP_INC = 4'd13,
    OP_DEC = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic acc;
    logic ext;
    logic cb;
  } wr_en_t;
endpackage

// File: rtl/acc_arith.sv
module acc_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           cb_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W:0] sum;
  logic [W:0] diff;

  assign sum  = {1'b0, a_i} + {1'b0, b_i};
  assign diff = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    res_o = a_i;
    cb_o  = 1'b0;
    case (op_i)
      OP_ADD: begin res_o = sum[W-1:0];  cb_o = sum[W];  end
      OP_SUB: begin res_o = diff[W-1:0]; cb_o = diff[W]; end
      OP_CMP: begin res_o = a_i;         cb_o = diff[W]; end
      OP_INC: begin res_o = a_i + ONE;   cb_o = (a_i == ONES); end
      OP_DEC: begin res_o = a_i - ONE;   cb_o = (a_i == '0);   end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_lo_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  assign prod      = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign prod_lo_o = prod[W-1:0];
  assign prod_hi_o = prod[PW-1:W];

  // restoring divider, one stage per dividend bit, MSB first
  logic [W-1:0] part [W+1];
  logic [W-1:0] quo;
  assign part[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_div
    logic [W:0]   trial;
    logic [W-1:0] red;
    assign trial        = {part[i], a_i[W-1-i]};
    assign quo[W-1-i]   = (trial >= {1'b0, b_i});
    assign red          = trial[W-1:0] - b_i;
    assign part[i+1]    = quo[W-1-i] ? red : trial[W-1:0];
  end

  // zero divisor: array yields all-ones quotient and remainder = dividend
  assign quo_o = quo;
  assign rem_o = part[W];
endmodule

// File: rtl/acc_shlog.sv
module acc_shlog
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_LSL:  res_o = {a_i[W-2:0], 1'b0};
      OP_LSR:  res_o = {1'b0, a_i[W-1:1]};
      OP_ROR:  res_o = {a_i[0], a_i[W-1:1]};
      OP_ROL:  res_o = {a_i[W-2:0], a_i[W-1]};
      OP_ASR:  res_o = {a_i[W-1], a_i[W-1:1]};
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         cb_i,
  input  logic [W-1:0] ext_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] ext_o,
  output logic         cb_o,
  output logic         acc_we_o,
  output logic         ext_we_o,
  output logic         cb_we_o
);
  alu_op_e      op;
  wr_en_t       we;
  logic [W-1:0] ar_res, sl_res, lo, hi, quo, rem;
  logic         ar_cb;
  logic [W-1:0] acc_nx, ext_nx;

  assign op = alu_op_e'(op_i);

  acc_arith  #(.W(W)) u_arith  (.op_i(op), .a_i(acc_i), .b_i(opnd_i),
                                .res_o(ar_res), .cb_o(ar_cb));
  acc_muldiv #(.W(W)) u_muldiv (.a_i(acc_i), .b_i(opnd_i),
                                .prod_lo_o(lo), .prod_hi_o(hi),
                                .quo_o(quo), .rem_o(rem));
  acc_shlog  #(.W(W)) u_shlog  (.op_i(op), .a_i(acc_i), .b_i(opnd_i),
                                .res_o(sl_res));

  always_comb begin
    we     = '0;
    acc_nx = acc_i;
    ext_nx = ext_i;
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        we.acc = 1'b1; we.cb = 1'b1; acc_nx = ar_res;
      end
      OP_CMP: we.cb = 1'b1;
      OP_MUL: begin
        we.acc = 1'b1; we.ext = 1'b1; acc_nx = lo; ext_nx = hi;
      end
      OP_DIV: begin
        we.acc = 1'b1; we.ext = 1'b1; acc_nx = quo; ext_nx = rem;
      end
      OP_LSL, OP_LSR, OP_ROR, OP_ROL, OP_ASR, OP_AND, OP_XOR: begin
        we.acc = 1'b1; acc_nx = sl_res;
      end
      default: ;
    endcase
  end

  assign acc_o    = acc_nx;
  assign ext_o    = ext_nx;
  assign cb_o     = we.cb ? ar_cb : cb_i;
  assign acc_we_o = we.acc;
  assign ext_we_o = we.ext;
  assign cb_we_o  = we.cb;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic         cb_i,
  input logic [W-1:0] ext_i,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] ext_o,
  input logic         cb_o,
  input logic         acc_we_o,
  input logic         ext_we_o,
  input logic         cb_we_o
);
  localparam logic [3:0] C_ADD = 4'd1, C_DIV = 4'd4, C_CMP = 4'd7,
                         C_INC = 4'd13, C_DEC = 4'd14;

  logic [2*W-1:0] recon;
  assign recon = {{W{1'b0}}, acc_o} * {{W{1'b0}}, opnd_i} + {{W{1'b0}}, ext_o};

  always_comb begin
    if (!acc_we_o) p_hold_acc_r1: assert (acc_o == acc_i) else $error("acc changed");
    if (!ext_we_o) p_hold_ext_r1: assert (ext_o == ext_i) else $error("ext changed");
    if (!cb_we_o)  p_hold_cb_r1:  assert (cb_o == cb_i)   else $error("cb changed");
    if (op_i == 4'd0 || op_i == 4'd15)
      p_idle_r1: assert (!acc_we_o && !ext_we_o && !cb_we_o) else $error("idle write");
    if (op_i == C_ADD)
      p_add_carry_r2: assert (cb_o == (acc_o < acc_i)) else $error("add carry");
    if (op_i == C_CMP)
      p_cmp_only_r4: assert (cb_we_o && !acc_we_o && !ext_we_o) else $error("cmp writes");
    if (op_i == C_DIV && opnd_i != '0)
      p_div_ident_r6: assert (recon == {{W{1'b0}}, acc_i} && ext_o < opnd_i)
        else $error("div identity");
    if (op_i >= 4'd8 && op_i <= 4'd12)
      p_shift_acc_only_r8: assert (acc_we_o && !ext_we_o && !cb_we_o) else $error("shift writes");
    if (op_i == C_INC)
      p_inc_wrap_r12: assert (cb_o == (acc_o == '0)) else $error("inc wrap");
    if (op_i == C_DEC)
      p_dec_wrap_r12: assert (cb_o == (acc_o == '1)) else $error("dec wrap");
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .cb_i(cb_i), .ext_i(ext_i),
  .acc_o(acc_o), .ext_o(ext_o), .cb_o(cb_o),
  .acc_we_o(acc_we_o), .ext_we_o(ext_we_o), .cb_we_o(cb_we_o)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [3:0] op_i;
  logic [7:0] acc_i, opnd_i, ext_i;
  logic       cb_i;
  logic [7:0] acc_o, ext_o;
  logic       cb_o, acc_we_o, ext_we_o, cb_we_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  acc_alu u_acc_alu (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .cb_i(cb_i), .ext_i(ext_i),
    .acc_o(acc_o), .ext_o(ext_o), .cb_o(cb_o),
    .acc_we_o(acc_we_o), .ext_we_o(ext_we_o), .cb_we_o(cb_we_o)
  );

  function automatic string tag(int o, int b);
    case (o)
      1: return "R2";   2: return "R3";   3: return "R5";
      4: return (b == 0) ? "R7" : "R6";
      5, 6: return "R11"; 7: return "R4";
      8, 9: return "R8"; 10, 11: return "R9"; 12: return "R10";
      13, 14: return "R12";
      default: return "R1";
    endcase
  endfunction

  task automatic check_one(int o, int a, int b, int c, int e);
    int ea = a, ee = e, ec = c;
    int wa = 0, wx = 0, wc = 0;
    case (o)
      1: begin ea = (a + b) % 256; ec = (a + b) / 256; wa = 1; wc = 1; end
      2: begin ea = (a - b + 256) % 256; ec = (a < b) ? 1 : 0; wa = 1; wc = 1; end
      3: begin ea = (a * b) % 256; ee = (a * b) / 256; wa = 1; wx = 1; end
      4: begin
        if (b == 0) begin ea = 255; ee = a; end
        else begin ea = a / b; ee = a % b; end
        wa = 1; wx = 1;
      end
      5: begin ea = a & b; wa = 1; end
      6: begin ea = a ^ b; wa = 1; end
      7: begin ec = (a < b) ? 1 : 0; wc = 1; end
      8: begin ea = (a * 2) % 256; wa = 1; end
      9: begin ea = a / 2; wa = 1; end
      10: begin ea = a / 2 + (a % 2) * 128; wa = 1; end
      11: begin ea = (a * 2) % 256 + a / 128; wa = 1; end
      12: begin ea = a / 2 + (a / 128) * 128; wa = 1; end
      13: begin ea = (a + 1) % 256; ec = (a == 255) ? 1 : 0; wa = 1; wc = 1; end
      14: begin ea = (a + 255) % 256; ec = (a == 0) ? 1 : 0; wa = 1; wc = 1; end
      default: ;
    endcase
    n_chk++;
    if (int'(acc_o) != ea || int'(ext_o) != ee || int'(cb_o) != ec ||
        int'(acc_we_o) != wa || int'(ext_we_o) != wx || int'(cb_we_o) != wc) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d: got acc=%0d ext=%0d cb=%0d we=%0d%0d%0d exp acc=%0d ext=%0d cb=%0d we=%0d%0d%0d",
               tag(o, b), o, a, b, acc_o, ext_o, cb_o, acc_we_o, ext_we_o, cb_we_o,
               ea, ee, ec, wa, wx, wc);
    end
  endtask

  initial begin
    op_i = 4'd0; acc_i = 8'h5A; opnd_i = 8'h33; cb_i = 1'b1; ext_i = 8'hC3;
    #15 rst_ni = 1'b1;
    #5;
    // idle state after reset: no-op passes everything through (R1)
    check_one(0, 8'h5A, 8'h33, 1, 8'hC3);
    for (int o = 0; o < 16; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          int c = (a + b + o) % 2;
          int e = (a * 7 + b * 3 + o) % 256;
          op_i = 4'(o); acc_i = 8'(a); opnd_i = 8'(b); cb_i = 1'(c); ext_i = 8'(e);
          #1;
          check_one(o, a, b, c, e);
          #1;
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 190000; k++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule